// File: doc/BRIEF.md
# Five-Level Transmit State Sequencer

This block drives one transmit channel of a multi-level high-voltage pulser. A short list of output levels is stored in a small on-chip table. On every repetition tick the block plays that list from the first entry: each level is presented as a one-hot code to the pulser driver. A normal entry lasts half of the pulse period, and an entry marked as a gap lasts a separately programmed dwell time. The five levels are clamp, positive rail 0, negative rail 0, positive rail 1 and negative rail 1.

Playback stops at an end-of-list code or after the last table entry. The output then rests at clamp until the next repetition tick restarts the list. A typical program places a three-step burst on rail 0, then a long clamp gap, then an alternating burst on rail 1, then clamp. Abort or a low run input drops the output to clamp in the same cycle.

Top module: `tx_level_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, level_o is 5'b00001 (clamp).
- R2: A table entry whose duration flag (data bit 3) is 0 holds its level for half_tp_i cycles; a value of 0 acts as 1.
- R3: A table entry whose duration flag is 1 holds its level for dwell_i cycles; a value of 0 acts as 1.
- R4: The cycle after run_i rises, playback starts at entry 0. It restarts at entry 0 every prf_i cycles after that, and a restart ends any playback still in progress.
- R5: Entries play in ascending address order, and each write through the table port replaces one entry. The state code sits in data bits 2:0: 0 clamp, 1 positive rail 0, 2 negative rail 0, 3 positive rail 1, 4 negative rail 1. level_o bit 0 is clamp, bit 1 positive rail 0, bit 2 negative rail 0, bit 3 positive rail 1 and bit 4 negative rail 1.
- R6: A state code of 5, 6 or 7, or finishing the last table entry, stops playback; level_o is clamp until the next restart.
- R7: While abort_i is high, level_o is clamp in that same cycle, and playback stays stopped until the next restart.
- R8: Exactly one bit of level_o is high in every cycle.
- R9: While run_i is low, level_o is clamp and the repetition timer is held, so no playback starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables the repetition timer and playback |
| abort_i | input | 1 | Forces clamp and stops the current playback |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 5 | Table entry address |
| wr_data_i | input | 4 | Bit 3 duration flag, bits 2:0 state code |
| half_tp_i | input | 16 | Cycles per normal entry (half pulse period) |
| dwell_i | input | 16 | Cycles per flagged entry |
| prf_i | input | 16 | Cycles between restarts |
| level_o | output | 5 | One-hot output level |

## Verification
The level is compared cycle by cycle against a waveform the bench derives from its own copy of the table. The full two-segment program, with a dwell gap, runs over two repetitions; this separates the normal duration from the dwell duration and confirms the repetition spacing. A mirrored program with a one-cycle half period and a zero half period checks that the state codes are mapped to the right rails and that a zero duration is treated as one cycle. A table with no end code shows that playback stops after the last entry. A mid-burst abort and a low run input show that the output goes to clamp at once and stays there until the next restart.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  localparam int unsigned N_LEVELS = 5;

  localparam logic [2:0] CODE_CLAMP = 3'd0;
  localparam logic [2:0] CODE_POS0  = 3'd1;
  localparam logic [2:0] CODE_NEG0  = 3'd2;
  localparam logic [2:0] CODE_POS1  = 3'd3;
  localparam logic [2:0] CODE_NEG1  = 3'd4;
  localparam logic [2:0] CODE_END   = 3'd7;

  typedef struct packed {
    logic       dwell;
    logic [2:0] code;
  } seq_entry_t;

  localparam logic [N_LEVELS-1:0] LEVEL_CLAMP = N_LEVELS'(1);

  function automatic logic is_end(input logic [2:0] code);
    return code > CODE_NEG1;
  endfunction

  function automatic logic [N_LEVELS-1:0] to_onehot(input logic [2:0] code);
    logic [N_LEVELS-1:0] oh;
    oh = '0;
    if (is_end(code)) oh = LEVEL_CLAMP;
    else              oh[code] = 1'b1;
    return oh;
  endfunction
endpackage

// File: rtl/seq_table.sv
module seq_table
  import tx_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  seq_entry_t    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output seq_entry_t    rd_data_o
);
  seq_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '{dwell: 1'b0, code: CODE_END};
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/prf_timer.sv
module prf_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] prf_i,
  output logic          tick_o
);
  logic [TW-1:0] cnt_q;
  logic          wrap;

  // prf_i of 0 behaves like 1
  assign wrap   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, prf_i};
  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (wrap)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
  import tx_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned TW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          stop_i,
  input  seq_entry_t    entry_i,
  input  logic [TW-1:0] half_tp_i,
  input  logic [TW-1:0] dwell_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          playing_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          playing_q;
  logic [AW-1:0] ptr_q;
  logic [TW-1:0] timer_q;
  logic [TW-1:0] dur;
  logic          step_done;

  assign dur       = entry_i.dwell ? dwell_i : half_tp_i;
  assign step_done = ({1'b0, timer_q} + 1'b1) >= {1'b0, dur};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      playing_q <= 1'b0;
      ptr_q     <= '0;
      timer_q   <= '0;
    end else if (stop_i) begin
      playing_q <= 1'b0;
    end else if (tick_i) begin
      playing_q <= 1'b1;
      ptr_q     <= '0;
      timer_q   <= '0;
    end else if (playing_q) begin
      if (is_end(entry_i.code)) begin
        playing_q <= 1'b0;
      end else if (step_done) begin
        timer_q <= '0;
        if (ptr_q == LAST) playing_q <= 1'b0;
        else               ptr_q     <= ptr_q + 1'b1;
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  assign rd_addr_o = ptr_q;
  assign playing_o = playing_q;
endmodule

// File: rtl/tx_level_seq.sv
module tx_level_seq
  import tx_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned TW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                abort_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [3:0]          wr_data_i,
  input  logic [TW-1:0]       half_tp_i,
  input  logic [TW-1:0]       dwell_i,
  input  logic [TW-1:0]       prf_i,
  output logic [N_LEVELS-1:0] level_o
);
  logic          tick_w;
  logic          stop_w;
  logic          playing_w;
  logic [AW-1:0] rd_addr_w;
  seq_entry_t    entry_w;

  assign stop_w = abort_i || !run_i;

  seq_table #(.DEPTH(DEPTH)) table_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (seq_entry_t'(wr_data_i)),
    .rd_addr_i (rd_addr_w),
    .rd_data_o (entry_w)
  );

  prf_timer #(.TW(TW)) prf_i_u (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .prf_i  (prf_i),
    .tick_o (tick_w)
  );

  step_ctrl #(.DEPTH(DEPTH), .TW(TW)) step_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .stop_i    (stop_w),
    .entry_i   (entry_w),
    .half_tp_i (half_tp_i),
    .dwell_i   (dwell_i),
    .rd_addr_o (rd_addr_w),
    .playing_o (playing_w)
  );

  // abort and run gate the level combinationally
  assign level_o = (playing_w && !stop_w) ? to_onehot(entry_w.code) : LEVEL_CLAMP;
endmodule

// File: rtl/tx_level_seq_chk.sv
module tx_level_seq_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned NL = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          abort_i,
  input logic [NL-1:0] level_o,
  input logic          tick_w,
  input logic          playing_w,
  input logic [AW-1:0] rd_addr_w
);
  localparam logic [NL-1:0] CLAMP = NL'(1);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clamp_chk: assert (level_o == CLAMP);
    end
  end

  // R8
  onehot_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(level_o) == 1);

  // R7
  abort_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |-> level_o == CLAMP);

  // R7
  abort_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !tick_w) |=> (!playing_w || $past(tick_w) == 1'b1));

  // R9
  run_low_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (level_o == CLAMP && !tick_w));

  // R4
  tick_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && !abort_i && run_i) |=> (playing_w && rd_addr_w == '0));

  // R5
  addr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (playing_w && $past(playing_w) && !$past(tick_w) && rd_addr_w != $past(rd_addr_w))
      |-> rd_addr_w == $past(rd_addr_w) + 1'b1);
endmodule

bind tx_level_seq tx_level_seq_chk #(.AW(AW), .NL(tx_seq_pkg::N_LEVELS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .abort_i   (abort_i),
  .level_o   (level_o),
  .tick_w    (tick_w),
  .playing_w (playing_w),
  .rd_addr_w (rd_addr_w)
);

// File: tb/tx_level_seq_tb_top.sv
module tx_level_seq_tb_top;
  localparam int DEPTH = 32;
  localparam int TW    = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          run_i = 1'b0;
  logic          abort_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [4:0]    wr_addr_i = '0;
  logic [3:0]    wr_data_i = '0;
  logic [TW-1:0] half_tp_i = '0;
  logic [TW-1:0] dwell_i = '0;
  logic [TW-1:0] prf_i = '0;
  logic [4:0]    level_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] tbl [DEPTH];

  always #10 clk_i = ~clk_i;

  tx_level_seq #(.DEPTH(DEPTH), .TW(TW)) dut_i (.*);

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp, input int s);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sample %0d: level_o=%b expected %b", req, s, act, exp);
    end
  endtask

  function automatic logic [4:0] onehot(input logic [2:0] c);
    logic [4:0] r;
    r = '0;
    r[c] = 1'b1;
    return r;
  endfunction

  // expected level t cycles after the start of a repetition
  function automatic logic [4:0] exp_at(input int t);
    int acc;
    int d;
    acc = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (tbl[i][2:0] > 3'd4) return 5'b00001;
      d = tbl[i][3] ? int'(dwell_i) : int'(half_tp_i);
      if (d == 0) d = 1;
      if (t < acc + d) return onehot(tbl[i][2:0]);
      acc += d;
    end
    return 5'b00001;
  endfunction

  task automatic wr(input int a, input logic dw, input logic [2:0] c);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_data_i = {dw, c};
    tbl[a] = {dw, c};
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < DEPTH; i++) wr(i, 1'b0, 3'd7);
  endtask

  // run n samples; abort pulsed at sample abort_at (-1 for none)
  task automatic play(input int n, input int abort_at, input string req);
    logic [4:0] e;
    @(negedge clk_i);
    run_i = 1'b1;
    for (int s = 0; s < n; s++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      abort_i = (s == abort_at);
      #1;
      if (abort_at >= 0 && s >= abort_at && s < int'(prf_i)) e = 5'b00001;
      else e = exp_at(s % int'(prf_i));
      check(req, level_o, e, s);
    end
    @(negedge clk_i);
    abort_i = 1'b0;
    run_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    #1;
    check("R1 in reset", level_o, 5'b00001, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", level_o, 5'b00001, 1);
  endtask

  task automatic t_main();
    clear_tbl();
    wr(0, 0, 3'd0); wr(1, 0, 3'd1); wr(2, 0, 3'd2); wr(3, 0, 3'd1);
    wr(4, 1, 3'd0);
    for (int i = 0; i < 8; i++) wr(5 + i, 0, (i % 2 == 0) ? 3'd3 : 3'd4);
    wr(13, 0, 3'd0); wr(14, 0, 3'd7);
    half_tp_i = 16'd3; dwell_i = 16'd10; prf_i = 16'd80;
    play(165, -1, "R2 R3 R4 R5 R6 main program");
  endtask

  task automatic t_mirror();
    clear_tbl();
    wr(0, 0, 3'd2); wr(1, 0, 3'd1); wr(2, 0, 3'd2); wr(3, 1, 3'd0);
    wr(4, 0, 3'd3); wr(5, 0, 3'd4); wr(6, 0, 3'd3); wr(7, 0, 3'd4);
    wr(8, 0, 3'd5);
    half_tp_i = 16'd1; dwell_i = 16'd5; prf_i = 16'd40;
    play(85, -1, "R2 R5 mirrored program");
    half_tp_i = 16'd0; dwell_i = 16'd0; prf_i = 16'd20;
    play(45, -1, "R2 R3 zero durations");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) wr(i, 0, (i % 2 == 0) ? 3'd3 : 3'd4);
    half_tp_i = 16'd2; dwell_i = 16'd4; prf_i = 16'd100;
    play(110, -1, "R6 last entry stops");
  endtask

  task automatic t_abort();
    clear_tbl();
    wr(0, 0, 3'd1); wr(1, 0, 3'd2); wr(2, 1, 3'd0); wr(3, 0, 3'd3); wr(4, 0, 3'd4);
    wr(5, 0, 3'd6);
    half_tp_i = 16'd4; dwell_i = 16'd6; prf_i = 16'd50;
    play(75, 5, "R7 abort mid burst");
  endtask

  task automatic t_run_low();
    run_i = 1'b0;
    for (int s = 0; s < 30; s++) begin
      @(negedge clk_i);
      #1;
      check("R9 run low holds clamp", level_o, 5'b00001, s);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl[i] = 4'h7;
    t_reset();
    t_main();
    t_mirror();
    t_full();
    t_abort();
    t_run_low();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule